// File: doc/BRIEF.md
# Floating-Point Aligning Adder with Sticky Bit

This block adds or subtracts two unpacked floating-point operands of one precision. Each operand is a 64-bit two's-complement fraction, left-justified with its sign in the MSB, and a 16-bit two's-complement exponent. The result goes to a later normalize and round stage. The sum mantissa is left unnormalized, and any one-bits lost on the way are folded into its LSB as a sticky indication.

For a subtraction, the second operand is negated inside the block before anything else happens. If either operand is zero, the other one passes through unchanged. Otherwise the operand with the smaller exponent is shifted arithmetically right to line up with the larger one. When the exponent gap is wider than the significant width of the precision, the smaller operand is swamped and the larger operand is returned as it is. A carry into the sign position is repaired by a one-place shift right with the exponent bumped. The result is registered, so it appears one clock after the input strobe.

Top module: `fpadd_align_top`

## Requirements
- R1: If the mantissa of `a` is zero, the result equals the (possibly negated) `b` operand, mantissa and exponent. Otherwise, if the effective `b` mantissa is zero, the result equals `a`.
- R2: With both operands nonzero and an exponent gap no larger than SIG_BITS (24 by default), the smaller-exponent mantissa is shifted arithmetically right by the gap, with its sign copied into the vacated bits. The sum then takes the larger exponent. When the exponents are equal, no shift happens.
- R3: If the exponent gap is greater than SIG_BITS, the result is the larger-exponent operand, unchanged, with no sticky bit.
- R4: Overflow occurs when the two aligned mantissas share a sign and the sum's MSB differs from it. On overflow, the sum is shifted right one place, the operands' common sign is written into the MSB, and the exponent rises by one.
- R5: If any one-bit leaves the mantissa during alignment or during the overflow shift, bit 0 of the result mantissa is set to 1.
- R6: When `sub` is 1, `b` is negated before the zero test and alignment. A `b` mantissa with only the MSB set becomes 0x4000_0000_0000_0000 with its exponent raised by one. Any other `b` mantissa is negated in two's complement.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and the result appears in that same cycle. While `in_valid` is low, `sum_mant` and `sum_exp` hold their values.
- R8: While `rst_n` is low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| sub | input | 1 | 1 = a - b, 0 = a + b |
| a_mant | input | 64 | First mantissa, two's complement, sign in MSB |
| a_exp | input | 16 | First exponent, two's complement |
| b_mant | input | 64 | Second mantissa |
| b_exp | input | 16 | Second exponent |
| out_valid | output | 1 | Result present |
| sum_mant | output | 64 | Unnormalized sum mantissa with sticky LSB |
| sum_exp | output | 16 | Sum exponent |

## Verification
The bench targets the boundaries where a plausible design slips:
- A gap of exactly SIG_BITS must still add, while one more must swamp. An off-by-one compare would drop a real contribution or add a term that should vanish.
- Negative-operand overflow must restore a 1 in the MSB. A plain logical shift would flip the sign of the result.
- Negating the most negative mantissa must yield one-half with a raised exponent. A bare two's-complement negate would return the same negative value.
- A lone one-bit shifted out, either during alignment or during the overflow fix, must show as the sticky LSB. Losing it would bias later rounding.
- A shift without sign extension would corrupt sums that involve a negative smaller operand.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int unsigned DEF_MANT_W = 64;
  localparam int unsigned DEF_EXP_W  = 16;
  localparam int unsigned DEF_SIG_BITS = 24;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpadd_op_e;
endpackage

// File: rtl/fpadd_negate.sv
module fpadd_negate #(
  parameter int unsigned MANT_W = 64,
  parameter int unsigned EXP_W  = 16
) (
  input  logic [MANT_W-1:0] in_mant,
  input  logic [EXP_W-1:0]  in_exp,
  output logic [MANT_W-1:0] out_mant,
  output logic [EXP_W-1:0]  out_exp
);
  localparam logic [MANT_W-1:0] MOST_NEG = {1'b1, {(MANT_W-1){1'b0}}};
  localparam logic [MANT_W-1:0] ONE_HALF = {2'b01, {(MANT_W-2){1'b0}}};

  always_comb begin
    if (in_mant == MOST_NEG) begin
      // -1.0 cannot be negated in place: renormalize as +0.5 one binade up
      out_mant = ONE_HALF;
      out_exp  = in_exp + 1'b1;
    end else begin
      out_mant = -in_mant;
      out_exp  = in_exp;
    end
  end
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int unsigned MANT_W = 64,
  parameter int unsigned SH_W   = 6
) (
  input  logic [MANT_W-1:0] mant_in,
  input  logic [SH_W-1:0]   shamt,
  output logic [MANT_W-1:0] mant_out,
  output logic              lost
);
  logic [MANT_W-1:0] drop_mask;

  always_comb begin
    drop_mask = ~({MANT_W{1'b1}} << shamt);
    mant_out  = $unsigned($signed(mant_in) >>> shamt);
    lost      = |(mant_in & drop_mask);
  end
endmodule

// File: rtl/fpadd_align_top.sv
module fpadd_align_top
  import fpadd_pkg::*;
#(
  parameter int unsigned MANT_W   = DEF_MANT_W,
  parameter int unsigned EXP_W    = DEF_EXP_W,
  parameter int unsigned SIG_BITS = DEF_SIG_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              sub,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] b_mant,
  input  logic [EXP_W-1:0]  b_exp,
  output logic              out_valid,
  output logic [MANT_W-1:0] sum_mant,
  output logic [EXP_W-1:0]  sum_exp
);
  localparam int unsigned SH_W = $clog2(MANT_W);
  localparam int unsigned DW   = EXP_W + 1;

  fpadd_op_e         op;
  logic [MANT_W-1:0] neg_mant, eb_mant;
  logic [EXP_W-1:0]  neg_exp, eb_exp;
  logic signed [DW-1:0] ediff;
  logic [DW-1:0]     magn;
  logic              a_bigger, swamped;
  logic [MANT_W-1:0] big_mant, small_mant, small_shifted;
  logic [EXP_W-1:0]  big_exp;
  logic [SH_W-1:0]   shamt;
  logic              align_lost;
  logic [MANT_W-1:0] raw_sum, fix_sum;
  logic              ovf;
  logic [MANT_W-1:0] nxt_mant;
  logic [EXP_W-1:0]  nxt_exp;
  logic              valid_q;
  logic [MANT_W-1:0] mant_q;
  logic [EXP_W-1:0]  exp_q;

  assign op = fpadd_op_e'(sub);

  fpadd_negate #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_neg (
    .in_mant (b_mant),
    .in_exp  (b_exp),
    .out_mant(neg_mant),
    .out_exp (neg_exp)
  );

  always_comb begin
    eb_mant  = (op == OP_SUB) ? neg_mant : b_mant;
    eb_exp   = (op == OP_SUB) ? neg_exp  : b_exp;
    ediff    = DW'($signed(a_exp)) - DW'($signed(eb_exp));
    a_bigger = (ediff > 0);
    magn     = a_bigger ? $unsigned(ediff) : $unsigned(-ediff);
    swamped  = (magn > DW'(SIG_BITS));
    big_mant   = a_bigger ? a_mant  : eb_mant;
    big_exp    = a_bigger ? a_exp   : eb_exp;
    small_mant = a_bigger ? eb_mant : a_mant;
    shamt      = swamped ? '0 : magn[SH_W-1:0];
  end

  fpadd_align #(.MANT_W(MANT_W), .SH_W(SH_W)) u_align (
    .mant_in (small_mant),
    .shamt   (shamt),
    .mant_out(small_shifted),
    .lost    (align_lost)
  );

  always_comb begin
    raw_sum = big_mant + small_shifted;
    ovf     = (big_mant[MANT_W-1] == small_shifted[MANT_W-1]) &&
              (raw_sum[MANT_W-1] != big_mant[MANT_W-1]);
    fix_sum = ovf ? {big_mant[MANT_W-1], raw_sum[MANT_W-1:1]} : raw_sum;
    if (a_mant == '0) begin
      nxt_mant = eb_mant;
      nxt_exp  = eb_exp;
    end else if (eb_mant == '0) begin
      nxt_mant = a_mant;
      nxt_exp  = a_exp;
    end else if (swamped) begin
      nxt_mant = big_mant;
      nxt_exp  = big_exp;
    end else begin
      nxt_mant = {fix_sum[MANT_W-1:1],
                  fix_sum[0] | align_lost | (ovf & raw_sum[0])};
      nxt_exp  = ovf ? big_exp + 1'b1 : big_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mant_q <= '0;
      exp_q  <= '0;
    end else if (in_valid) begin
      mant_q <= nxt_mant;
      exp_q  <= nxt_exp;
    end
  end

  assign out_valid = valid_q;
  assign sum_mant  = mant_q;
  assign sum_exp   = exp_q;
endmodule

// File: rtl/fpadd_align_chk.sv
module fpadd_align_chk #(
  parameter int unsigned MANT_W   = 64,
  parameter int unsigned EXP_W    = 16,
  parameter int unsigned SIG_BITS = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              sub,
  input logic [MANT_W-1:0] a_mant,
  input logic [EXP_W-1:0]  a_exp,
  input logic [MANT_W-1:0] b_mant,
  input logic [EXP_W-1:0]  b_exp,
  input logic              out_valid,
  input logic [MANT_W-1:0] sum_mant,
  input logic [EXP_W-1:0]  sum_exp
);
  logic signed [EXP_W:0] gap;
  logic both_nz;
  assign gap     = (EXP_W+1)'($signed(a_exp)) - (EXP_W+1)'($signed(b_exp));
  assign both_nz = (a_mant != '0) && (b_mant != '0) && !sub;

  // R7
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum_mant) && $stable(sum_exp)));
  // R1
  assert_zero_a_passes_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub && a_mant == '0) |=>
      (sum_mant == $past(b_mant) && sum_exp == $past(b_exp)));
  assert_zero_b_passes_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub && b_mant == '0 && a_mant != '0) |=>
      (sum_mant == $past(a_mant) && sum_exp == $past(a_exp)));
  // R3
  assert_swamp_keeps_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && both_nz && gap > $signed((EXP_W+1)'(SIG_BITS))) |=>
      (sum_mant == $past(a_mant) && sum_exp == $past(a_exp)));
  // R2 / R4: exponent is the larger one, possibly plus one
  assert_exp_from_larger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && both_nz && gap >= 0) |=>
      (sum_exp == $past(a_exp) || sum_exp == $past(a_exp) + 1'b1));
endmodule

bind fpadd_align_top fpadd_align_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .SIG_BITS(SIG_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub(sub),
  .a_mant(a_mant), .a_exp(a_exp), .b_mant(b_mant), .b_exp(b_exp),
  .out_valid(out_valid), .sum_mant(sum_mant), .sum_exp(sum_exp)
);

// File: tb/fpadd_align_top_test.sv
module fpadd_align_top_test;
  typedef struct packed {
    logic [63:0] am;
    logic [15:0] ae;
    logic [63:0] bm;
    logic [15:0] be;
    logic        s;
    logic [63:0] xm;
    logic [15:0] xe;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 zero a
    '{64'h0, 16'd5, 64'h4000_0000_0000_0000, 16'd3, 1'b0, 64'h4000_0000_0000_0000, 16'd3, 8'd1},
    // R1 zero b
    '{64'h6000_0000_0000_0000, 16'd2, 64'h0, 16'd9, 1'b0, 64'h6000_0000_0000_0000, 16'd2, 8'd1},
    // R2 equal exponents
    '{64'h2000_0000_0000_0000, 16'd1, 64'h1000_0000_0000_0000, 16'd1, 1'b0, 64'h3000_0000_0000_0000, 16'd1, 8'd2},
    // R2 align b by 2
    '{64'h4000_0000_0000_0000, 16'd4, 64'h4000_0000_0000_0000, 16'd2, 1'b0, 64'h5000_0000_0000_0000, 16'd4, 8'd2},
    // R5 sticky from alignment
    '{64'h4000_0000_0000_0000, 16'd3, 64'h4000_0000_0000_0001, 16'd0, 1'b0, 64'h4800_0000_0000_0001, 16'd3, 8'd5},
    // R4 positive overflow
    '{64'h6000_0000_0000_0000, 16'd0, 64'h6000_0000_0000_0000, 16'd0, 1'b0, 64'h6000_0000_0000_0000, 16'd1, 8'd4},
    // R4 negative overflow keeps sign
    '{64'h9000_0000_0000_0000, 16'd2, 64'hA000_0000_0000_0000, 16'd2, 1'b0, 64'h9800_0000_0000_0000, 16'd3, 8'd4},
    // R5 sticky from overflow shift
    '{64'h6000_0000_0000_0001, 16'd0, 64'h6000_0000_0000_0000, 16'd0, 1'b0, 64'h6000_0000_0000_0001, 16'd1, 8'd5},
    // R3 gap 25 swamps
    '{64'h4000_0000_0000_0000, 16'd30, 64'h4000_0000_0000_0000, 16'd5, 1'b0, 64'h4000_0000_0000_0000, 16'd30, 8'd3},
    // R3 gap 24 still adds
    '{64'h4000_0000_0000_0000, 16'd29, 64'h4000_0000_0000_0000, 16'd5, 1'b0, 64'h4000_0040_0000_0000, 16'd29, 8'd3},
    // R2 a is the smaller one
    '{64'h4000_0000_0000_0000, 16'd0, 64'h4000_0000_0000_0000, 16'd1, 1'b0, 64'h6000_0000_0000_0000, 16'd1, 8'd2},
    // R6 plain subtract
    '{64'h6000_0000_0000_0000, 16'd0, 64'h2000_0000_0000_0000, 16'd0, 1'b1, 64'h4000_0000_0000_0000, 16'd0, 8'd6},
    // R6 subtract most negative
    '{64'h4000_0000_0000_0000, 16'd0, 64'h8000_0000_0000_0000, 16'd0, 1'b1, 64'h6000_0000_0000_0000, 16'd1, 8'd6},
    // R6 negate before zero test
    '{64'h0, 16'd7, 64'h2000_0000_0000_0000, 16'd3, 1'b1, 64'hE000_0000_0000_0000, 16'd3, 8'd6},
    // R2 negative smaller operand sign-extended, plus negative exponents below
    '{64'h4000_0000_0000_0000, 16'd2, 64'hC000_0000_0000_0000, 16'd0, 1'b0, 64'h3000_0000_0000_0000, 16'd2, 8'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, sub;
  logic [63:0] a_mant, b_mant;
  logic [15:0] a_exp, b_exp;
  logic        out_valid;
  logic [63:0] sum_mant;
  logic [15:0] sum_exp;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fpadd_align_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub(sub),
    .a_mant(a_mant), .a_exp(a_exp), .b_mant(b_mant), .b_exp(b_exp),
    .out_valid(out_valid), .sum_mant(sum_mant), .sum_exp(sum_exp)
  );

  task automatic drive(input logic [63:0] am, input logic [15:0] ae,
                       input logic [63:0] bm, input logic [15:0] be, input logic s);
    @(negedge clk);
    in_valid = 1'b1; sub = s;
    a_mant = am; a_exp = ae; b_mant = bm; b_exp = be;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_res(input string tag, input logic [63:0] xm, input logic [15:0] xe);
    checks++;
    if (out_valid !== 1'b1 || sum_mant !== xm || sum_exp !== xe) begin
      errors++;
      $display("FAIL %s: got v=%b m=%h e=%h, expected v=1 m=%h e=%h",
               tag, out_valid, sum_mant, sum_exp, xm, xe);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; sub = 1'b0;
    a_mant = '0; b_mant = '0; a_exp = '0; b_exp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;  // R8 reset state
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].am, VECS[i].ae, VECS[i].bm, VECS[i].be, VECS[i].s);
      check_res($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].xm, VECS[i].xe);
    end

    // R2 negative exponents: -3 vs -1, result exponent -1
    drive(64'h4000_0000_0000_0000, 16'hFFFD, 64'h4000_0000_0000_0000, 16'hFFFF, 1'b0);
    check_res("R2 negative exponents", 64'h5000_0000_0000_0000, 16'hFFFF);

    // R7 valid drops and data holds without in_valid
    @(negedge clk);
    a_mant = 64'h1234_0000_0000_0000; b_mant = 64'h2222_0000_0000_0000;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sum_mant !== 64'h5000_0000_0000_0000 || sum_exp !== 16'hFFFF) begin
      errors++;
      $display("FAIL R7: got v=%b m=%h e=%h, expected v=0 m=5000000000000000 e=ffff",
               out_valid, sum_mant, sum_exp);
    end

    // R8 reset mid-run clears out_valid
    in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R8: out_valid=%b after reset, expected 0", out_valid);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule